// File: doc/BRIEF.md
# Two-Step Pulse-Pair Estimator

This block turns a stream of target samples into a train of ternary pulses that drive a switching stage feeding a second-order averaging filter. Every other clock it takes one target sample and, for each of the nine ordered pairs of pulses drawn from {-1, 0, +1}, predicts where the modelled filter output will stand two pulse periods ahead. The pair whose prediction lies closest to the target is chosen. Its two pulses go out on consecutive clocks, and the two-element model state jumps forward by two steps under that pair.

All model coefficients arrive as inputs, already folded into two-step form: a 2x2 transition matrix, the state gains for the first and second pulse of a pair, a row that maps the state to the output, and the output gains for the two pulses. Numbers are 16-bit signed fixed point with `FRAC` fraction bits (default 12, so 4096 is 1.0). Every result is clamped to the range -32768..32767.

The nine errors are registered between the prediction stage and the selector. The selector compares all pairs of candidates at once and picks the winner with AND trees over those comparisons. No sequential comparator chain is used.

Top module: `tspa_pair_est`

## Requirements
- R1: While reset is low and on the first clock after it is released, `pulse_o` is 00 (zero pulse) and `lead_o` is 0. The model state starts at zero.
- R2: The target is sampled on the first rising edge after reset is released and then on every second edge after that. Its value at the other edges has no effect on any pulse.
- R3: `pulse_o` uses 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1. The code 2'b10 never appears.
- R4: A target sampled at edge n yields its first pulse u0 on `pulse_o` with `lead_o`=1 after edge n+1. The second pulse u1 follows after edge n+2 with `lead_o`=0.
- R5: Candidate i has u0 = i/3 - 1 and u1 = i%3 - 1. Its prediction is sat(floor((view_a*xa + view_b*xb) / 2^FRAC) + u0*view0 + u1*view1).
- R6: The error of a candidate is min(|target - prediction|, 32767). The emitted pair has the least error of the nine.
- R7: When several candidates share the least error, the one with the highest index i is emitted.
- R8: At each decision the state advances once, to xa' = sat(floor((trans_aa*xa + trans_ab*xb) / 2^FRAC) + u0*drive0_a + u1*drive1_a). xb' follows the same form with trans_ba, trans_bb, drive0_b and drive1_b. Between decisions the state holds.
- R9: Predictions and state values saturate at 32767 and -32768 rather than wrapping.
- R10: Exactly one candidate wins every decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pulse-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_i | input | 16 | Target sample, signed; read every other edge |
| trans_aa | input | 16 | Two-step transition matrix, row a column a |
| trans_ab | input | 16 | Two-step transition matrix, row a column b |
| trans_ba | input | 16 | Two-step transition matrix, row b column a |
| trans_bb | input | 16 | Two-step transition matrix, row b column b |
| drive0_a | input | 16 | State a gain of the first pulse |
| drive0_b | input | 16 | State b gain of the first pulse |
| drive1_a | input | 16 | State a gain of the second pulse |
| drive1_b | input | 16 | State b gain of the second pulse |
| view_a | input | 16 | Output weight of state a after two steps |
| view_b | input | 16 | Output weight of state b after two steps |
| view0 | input | 16 | Output gain of the first pulse |
| view1 | input | 16 | Output gain of the second pulse |
| pulse_o | output | 2 | Ternary pulse code |
| lead_o | output | 1 | High when `pulse_o` carries the first pulse of a pair |

## Verification
Two things happen on the same sampling edge. The held second pulse of the previous pair goes out, and the nine errors for the next pair are computed from the state that the previous decision has just written. The bench runs pairs back to back with nonzero transition matrices and saturating coefficients, so a stale or early state read would change the chosen pairs. The target is also moved to extreme values on every non-sampling edge. A software model of the requirements predicts every pulse and every `lead_o` value, and each clock is compared against it, including designed ties where the highest index must win.

// File: rtl/tspa_pkg.sv
package tspa_pkg;

    typedef enum logic [1:0] {
        P_ZERO = 2'b00,
        P_POS  = 2'b01,
        P_NEG  = 2'b11
    } pulse_e;

    // level digit 0,1,2 stands for pulse -1,0,+1
    function automatic pulse_e lvl_to_pulse(input int d);
        case (d)
            0:       return P_NEG;
            1:       return P_ZERO;
            default: return P_POS;
        endcase
    endfunction

endpackage

// File: rtl/tspa_dot.sv
// Two-term fixed-point dot product, scaled down by 2^FRAC (floor), full width.
module tspa_dot #(
    parameter int W    = 16,
    parameter int FRAC = 12
) (
    input  logic signed [W-1:0] c0_i,
    input  logic signed [W-1:0] c1_i,
    input  logic signed [W-1:0] v0_i,
    input  logic signed [W-1:0] v1_i,
    output logic signed [2*W:0] base_o
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] prod0, prod1;
    logic signed [PW:0]   acc;

    assign prod0  = PW'(c0_i) * PW'(v0_i);
    assign prod1  = PW'(c1_i) * PW'(v1_i);
    assign acc    = $signed({prod0[PW-1], prod0}) + $signed({prod1[PW-1], prod1});
    assign base_o = acc >>> FRAC;
endmodule

// File: rtl/tspa_sum.sv
// Adds the two pulse contributions to a scaled base and saturates to W bits.
module tspa_sum import tspa_pkg::*; #(
    parameter int W = 16
) (
    input  logic signed [2*W:0] base_i,
    input  logic signed [W-1:0] k0_i,
    input  logic signed [W-1:0] k1_i,
    input  pulse_e              u0_i,
    input  pulse_e              u1_i,
    output logic signed [W-1:0] y_o
);
    localparam int SW = 2 * W + 3;
    localparam logic signed [SW-1:0] HI = SW'(2 ** (W - 1) - 1);
    localparam logic signed [SW-1:0] LO = ~HI;

    logic signed [SW-1:0] t0, t1, total;

    always_comb begin
        case (u0_i)
            P_POS:   t0 = SW'(k0_i);
            P_NEG:   t0 = -SW'(k0_i);
            default: t0 = '0;
        endcase
        case (u1_i)
            P_POS:   t1 = SW'(k1_i);
            P_NEG:   t1 = -SW'(k1_i);
            default: t1 = '0;
        endcase
        total = SW'(base_i) + t0 + t1;
        if (total > HI)      y_o = HI[W-1:0];
        else if (total < LO) y_o = LO[W-1:0];
        else                 y_o = total[W-1:0];
    end
endmodule

// File: rtl/tspa_pick.sv
// All-pairs comparison; winner is <= every lower index and < every higher index.
module tspa_pick #(
    parameter int W  = 16,
    parameter int NC = 9
) (
    input  logic [NC-1:0][W-1:0] err_i,
    output logic [NC-1:0]        win_o
);
    for (genvar i = 0; i < NC; i++) begin : g_row
        logic [NC-1:0] beats;
        for (genvar j = 0; j < NC; j++) begin : g_col
            if (j < i) begin : g_lo
                assign beats[j] = (err_i[i] <= err_i[j]);
            end else if (j > i) begin : g_hi
                assign beats[j] = (err_i[i] < err_i[j]);
            end else begin : g_self
                assign beats[j] = 1'b1;
            end
        end
        assign win_o[i] = &beats;
    end
endmodule

// File: rtl/tspa_pair_est.sv
module tspa_pair_est import tspa_pkg::*; #(
    parameter int W    = 16,
    parameter int FRAC = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] tgt_i,
    input  logic signed [W-1:0] trans_aa,
    input  logic signed [W-1:0] trans_ab,
    input  logic signed [W-1:0] trans_ba,
    input  logic signed [W-1:0] trans_bb,
    input  logic signed [W-1:0] drive0_a,
    input  logic signed [W-1:0] drive0_b,
    input  logic signed [W-1:0] drive1_a,
    input  logic signed [W-1:0] drive1_b,
    input  logic signed [W-1:0] view_a,
    input  logic signed [W-1:0] view_b,
    input  logic signed [W-1:0] view0,
    input  logic signed [W-1:0] view1,
    output logic [1:0]          pulse_o,
    output logic                lead_o
);
    localparam int LEV = 3;
    localparam int NC  = LEV * LEV;
    localparam logic [W-1:0] EMAX = {1'b0, {(W-1){1'b1}}};

    typedef struct packed {
        logic                 phase;   // 1: errors are registered, decide next edge
        logic signed [W-1:0]  xa;
        logic signed [W-1:0]  xb;
        logic [NC-1:0][W-1:0] err;
        pulse_e               cur;
        pulse_e               held;
        logic                 lead;
    } st_t;

    st_t q, d;

    function automatic logic [W-1:0] abs_err(input logic signed [W-1:0] t,
                                             input logic signed [W-1:0] p);
        logic signed [W:0] dif;
        logic [W:0]        mag;
        dif = $signed({t[W-1], t}) - $signed({p[W-1], p});
        mag = dif[W] ? $unsigned(-dif) : $unsigned(dif);
        if (mag > {1'b0, EMAX}) return EMAX;
        return mag[W-1:0];
    endfunction

    // prediction path
    logic signed [2*W:0]  base_y, base_a, base_b;
    logic signed [W-1:0]  pred [NC];
    logic [NC-1:0][W-1:0] err_c;

    tspa_dot #(.W(W), .FRAC(FRAC)) u_dot_y (
        .c0_i(view_a), .c1_i(view_b), .v0_i(q.xa), .v1_i(q.xb), .base_o(base_y));

    for (genvar g = 0; g < NC; g++) begin : g_cand
        localparam pulse_e U0 = lvl_to_pulse(g / LEV);
        localparam pulse_e U1 = lvl_to_pulse(g % LEV);
        tspa_sum #(.W(W)) u_pred (
            .base_i(base_y), .k0_i(view0), .k1_i(view1),
            .u0_i(U0), .u1_i(U1), .y_o(pred[g]));
        assign err_c[g] = abs_err(tgt_i, pred[g]);
    end

    // selection path
    logic [NC-1:0] win;
    pulse_e        win_u0, win_u1;

    tspa_pick #(.W(W), .NC(NC)) u_pick (.err_i(q.err), .win_o(win));

    always_comb begin
        win_u0 = P_ZERO;
        win_u1 = P_ZERO;
        for (int i = 0; i < NC; i++) begin
            if (win[i]) begin
                win_u0 = lvl_to_pulse(i / LEV);
                win_u1 = lvl_to_pulse(i % LEV);
            end
        end
    end

    // state advance path
    logic signed [W-1:0] xa_c, xb_c;

    tspa_dot #(.W(W), .FRAC(FRAC)) u_dot_a (
        .c0_i(trans_aa), .c1_i(trans_ab), .v0_i(q.xa), .v1_i(q.xb), .base_o(base_a));
    tspa_dot #(.W(W), .FRAC(FRAC)) u_dot_b (
        .c0_i(trans_ba), .c1_i(trans_bb), .v0_i(q.xa), .v1_i(q.xb), .base_o(base_b));

    tspa_sum #(.W(W)) u_next_a (
        .base_i(base_a), .k0_i(drive0_a), .k1_i(drive1_a),
        .u0_i(win_u0), .u1_i(win_u1), .y_o(xa_c));
    tspa_sum #(.W(W)) u_next_b (
        .base_i(base_b), .k0_i(drive0_b), .k1_i(drive1_b),
        .u0_i(win_u0), .u1_i(win_u1), .y_o(xb_c));

    always_comb begin
        d       = q;
        d.phase = ~q.phase;
        if (!q.phase) begin
            d.err  = err_c;
            d.cur  = q.held;
            d.lead = 1'b0;
        end else begin
            d.xa   = xa_c;
            d.xb   = xb_c;
            d.cur  = win_u0;
            d.held = win_u1;
            d.lead = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pulse_o = q.cur;
    assign lead_o  = q.lead;
endmodule

// File: rtl/tspa_pair_est_chk.sv
module tspa_pair_est_chk #(
    parameter int W  = 16,
    parameter int NC = 9
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 phase_i,
    input logic [NC-1:0]        win_i,
    input logic [NC-1:0][W-1:0] err_i,
    input logic [1:0]           pulse_i,
    input logic                 lead_i,
    input logic [1:0]           held_i,
    input logic [W-1:0]         xa_i,
    input logic [W-1:0]         xb_i
);
    p_one_winner_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_i |-> $onehot(win_i));

    p_legal_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_i != 2'b10);

    p_lead_after_decide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_i |=> lead_i);

    p_second_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lead_i |=> (!lead_i && pulse_i == $past(held_i)));

    p_state_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phase_i |=> (xa_i == $past(xa_i) && xb_i == $past(xb_i)));

    for (genvar i = 0; i < NC; i++) begin : g_i
        for (genvar j = 0; j < NC; j++) begin : g_j
            if (j < i) begin : g_lo
                p_least_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (phase_i && win_i[i]) |-> err_i[i] <= err_i[j]);
            end else if (j > i) begin : g_hi
                p_tie_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (phase_i && win_i[i]) |-> err_i[i] < err_i[j]);
            end
        end
    end
endmodule

bind tspa_pair_est tspa_pair_est_chk #(.W(W), .NC(NC)) u_chk (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(q.phase), .win_i(win), .err_i(q.err),
    .pulse_i(pulse_o), .lead_i(lead_o), .held_i(q.held), .xa_i(q.xa), .xb_i(q.xb));

// File: tb/tspa_pair_est_tb.sv
module tspa_pair_est_tb;
    localparam int W          = 16;
    localparam int FRAC       = 12;
    localparam int CLK_PERIOD = 10;
    localparam longint HI     = 32767;
    localparam longint LO     = -32768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [W-1:0] tgt_i = '0;
    logic signed [W-1:0] trans_aa, trans_ab, trans_ba, trans_bb;
    logic signed [W-1:0] drive0_a, drive0_b, drive1_a, drive1_b;
    logic signed [W-1:0] view_a, view_b, view0, view1;
    logic [1:0] pulse_o;
    logic       lead_o;

    tspa_pair_est #(.W(W), .FRAC(FRAC)) u_dut (
        .clk(clk), .rst_n(rst_n), .tgt_i(tgt_i),
        .trans_aa(trans_aa), .trans_ab(trans_ab), .trans_ba(trans_ba), .trans_bb(trans_bb),
        .drive0_a(drive0_a), .drive0_b(drive0_b), .drive1_a(drive1_a), .drive1_b(drive1_b),
        .view_a(view_a), .view_b(view_b), .view0(view0), .view1(view1),
        .pulse_o(pulse_o), .lead_o(lead_o));

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int illegal = 0;
    longint mxa, mxb;
    int tg [64];

    always @(negedge clk) if (rst_n && pulse_o == 2'b10) illegal++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint satw(input longint v);
        if (v > HI) return HI;
        if (v < LO) return LO;
        return v;
    endfunction

    function automatic longint dotf(input longint c0, c1, v0, v1);
        return (c0 * v0 + c1 * v1) >>> FRAC;
    endfunction

    function automatic logic [1:0] code(input int u);
        if (u > 0) return 2'b01;
        if (u < 0) return 2'b11;
        return 2'b00;
    endfunction

    // reference decision from the requirements; advances the model state
    task automatic model_pair(input longint t, output int u0, output int u1);
        longint b, pr, e, best;
        int bi;
        b = dotf(view_a, view_b, mxa, mxb);
        best = 1 << 30;
        bi = 0;
        for (int i = 0; i < 9; i++) begin
            pr = satw(b + longint'(i / 3 - 1) * view0 + longint'(i % 3 - 1) * view1);
            e = t - pr;
            if (e < 0) e = -e;
            if (e > HI) e = HI;
            if (e <= best) begin best = e; bi = i; end
        end
        u0 = bi / 3 - 1;
        u1 = bi % 3 - 1;
        b   = satw(dotf(trans_aa, trans_ab, mxa, mxb) + u0 * drive0_a + u1 * drive1_a);
        mxb = satw(dotf(trans_ba, trans_bb, mxa, mxb) + u0 * drive0_b + u1 * drive1_b);
        mxa = b;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        tgt_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pulse_o == 2'b00 && !lead_o, "R1 reset outputs", {lead_o, pulse_o}, 0);
        mxa = 0;
        mxb = 0;
        rst_n = 1'b1;
    endtask

    // drives n targets from tg[], junk on off edges, checks every pulse
    task automatic run_pairs(input int n, input string tag);
        int u0, u1, pu1;
        pu1 = 0;
        for (int p = 0; p < n; p++) begin
            tgt_i = W'(tg[p]);
            @(posedge clk); @(negedge clk);
            if (p == 0)
                chk(pulse_o == 2'b00 && !lead_o, "R1 first cycle after reset", {lead_o, pulse_o}, 0);
            else
                chk(pulse_o == code(pu1) && !lead_o, {tag, " second pulse"},
                    {lead_o, pulse_o}, {1'b0, code(pu1)});
            tgt_i = (p % 2 == 0) ? 16'sh7fff : 16'sh8000;  // R2: must be ignored
            model_pair(tg[p], u0, u1);
            pu1 = u1;
            @(posedge clk); @(negedge clk);
            chk(pulse_o == code(u0) && lead_o, {tag, " first pulse"},
                {lead_o, pulse_o}, {1'b1, code(u0)});
        end
        tgt_i = '0;
        @(posedge clk); @(negedge clk);
        chk(pulse_o == code(pu1) && !lead_o, {tag, " last second pulse"},
            {lead_o, pulse_o}, {1'b0, code(pu1)});
        chk(illegal == 0, "R3 no 2'b10 code", illegal, 0);
    endtask

    task automatic set_coef(input int aa, ab, ba, bb, d0a, d0b, d1a, d1b, va, vb, v0, v1);
        trans_aa = W'(aa); trans_ab = W'(ab); trans_ba = W'(ba); trans_bb = W'(bb);
        drive0_a = W'(d0a); drive0_b = W'(d0b); drive1_a = W'(d1a); drive1_b = W'(d1b);
        view_a = W'(va); view_b = W'(vb); view0 = W'(v0); view1 = W'(v1);
    endtask

    // zero state, ties between candidates, ignored off-edge targets
    task automatic test_ties();
        set_coef(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4096, 2048);
        apply_reset();
        tg[0] = -2048; tg[1] = 1229; tg[2] = 6144; tg[3] = -32768;
        tg[4] = 0;     tg[5] = 2048; tg[6] = -4096; tg[7] = 32767;
        run_pairs(8, "R2 R3 R6 R7");
    endtask

    task automatic test_dynamics();
        set_coef(4000, -300, 500, 3900, 200, -100, 150, 50, 3000, 1000, 400, 250);
        apply_reset();
        for (int p = 0; p < 40; p++) tg[p] = ((p * 1500) % 12000) - 6000;
        run_pairs(40, "R4 R5 R8 R10");
    endtask

    task automatic test_saturation();
        set_coef(32767, 0, 0, 32767, 30000, -30000, 30000, 1000, 32767, -32768, 32767, -32768);
        apply_reset();
        for (int p = 0; p < 24; p++) tg[p] = (p % 3 == 0) ? 32767 : ((p % 3 == 1) ? -32768 : 100);
        run_pairs(24, "R5 R9");
    endtask

    initial begin
        set_coef(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        test_ties();
        test_dynamics();
        test_saturation();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule